// File: doc/BRIEF.md
# Flit Link Transmitter with Replay and Credit Gating

This block is the sending half of a point-to-point link layer. Upstream logic hands it fixed-width payload words over a valid/ready handshake. The block appends a 16-bit CRC to each one and sends the result as a flit, tagged with a sequence number. Every sent flit stays in a replay store until the far end acknowledges it.

A sideband port carries three kinds of returns from the receiver. An acknowledge releases stored flits. A negative acknowledge reports a failed CRC check and makes the block resend stored flits in their original order, with no help from upstream. A credit return pulse frees one slot in the receiver's buffer.

The block counts receiver credits. It stops taking new payloads when the credits run out or when the replay store is full. Serialization, line coding and anything above the link layer are handled elsewhere.

Top module: `flit_tx_link`

## Requirements
- R1: Each sent flit carries the payload in its upper bits and a CRC in its lowest 16 bits. The CRC uses polynomial 0x1021 and seed 0xFFFF. It is computed over the payload MSB first, with no reflection and no final inversion.
- R2: A payload accepted on a clock edge (in_valid and in_ready both high) appears on tx_flit with tx_valid high right after that same edge. New flits carry sequence numbers 0, 1, 2, … after reset, wrapping modulo DEPTH.
- R3: After reset, tx_valid is low and in_ready is high.
- R4: The credit count starts at RX_BUF. Each new flit sent lowers it by one, and each cycle with credit_ret high raises it by one.
- R5: While the credit count is zero, in_ready is low. It rises again once a credit is returned and the other conditions allow it.
- R6: An acknowledge carrying sequence N releases every stored flit from the oldest one up to and including N.
- R7: A negative acknowledge carrying sequence N rewinds to N. Starting on the second clock edge after the one that samples it, the block resends every stored flit from N onward, one per cycle, in order, with identical flit content and sequence number. While the replay runs, in_ready stays low.
- R8: Resent flits do not consume credits.
- R9: When DEPTH flits are stored, in_ready is low even if credits remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Upstream payload valid |
| in_ready | output | 1 | Block can accept a payload |
| in_data | input | PAYLOAD_W (32) | Upstream payload |
| tx_valid | output | 1 | Flit valid this cycle |
| tx_flit | output | PAYLOAD_W+16 (48) | Payload followed by CRC |
| tx_seq | output | log2(DEPTH) (3) | Sequence number of the flit |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_seq | input | log2(DEPTH) (3) | Newest sequence being acknowledged |
| nak_valid | input | 1 | Negative-acknowledge strobe |
| nak_seq | input | log2(DEPTH) (3) | Sequence to resend from |
| credit_ret | input | 1 | One receiver credit returned |

## Verification
The assertions assume that the sideband behaves like a sane receiver. Acknowledge and negative-acknowledge sequences always name a flit that is currently stored. The two strobes never arrive in the same cycle. Credit returns never push the count above RX_BUF.

The stimulus keeps to these assumptions by keeping a model of the stored window and of the credit count. It acknowledges or rewinds only to sequences inside that window, and it returns only credits that were spent.

// File: rtl/flit_tx_pkg.sv
package flit_tx_pkg;
  localparam int unsigned CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  // one serial CRC step, MSB-first
  function automatic logic [15:0] crc_step(input logic [15:0] cur, input logic bit_in);
    logic fb;
    logic [15:0] nxt;
    fb  = cur[15] ^ bit_in;
    nxt = {cur[14:0], 1'b0};
    if (fb) nxt = nxt ^ CRC_POLY;
    return nxt;
  endfunction
endpackage

// File: rtl/flit_crc16.sv
module flit_crc16 #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] data,
  output logic [15:0]       crc
);
  import flit_tx_pkg::*;

  always_comb begin
    logic [15:0] acc;
    acc = CRC_SEED;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      acc = crc_step(acc, data[i]);
    end
    crc = acc;
  end
endmodule

// File: rtl/flit_replay_buf.sv
module flit_replay_buf #(
  parameter int unsigned WIDTH = 48,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == AW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/flit_credit_ctr.sv
module flit_credit_ctr #(
  parameter int unsigned RX_BUF = 6,
  localparam int unsigned CW = $clog2(RX_BUF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          has_credit
);
  logic [CW-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (inc && !dec)      count_d = count_q + CW'(1);
    else if (dec && !inc) count_d = count_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= CW'(RX_BUF);
    else        count_q <= count_d;
  end

  assign count      = count_q;
  assign has_credit = (count_q != '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (count_q != '0)); // R5
  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(RX_BUF)); // R4
endmodule

// File: rtl/flit_tx_link.sv
module flit_tx_link #(
  parameter int unsigned PAYLOAD_W = 32,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned RX_BUF    = 6,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned FLIT_W = PAYLOAD_W + 16,
  localparam int unsigned CW     = $clog2(RX_BUF + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PAYLOAD_W-1:0] in_data,
  output logic                 tx_valid,
  output logic [FLIT_W-1:0]    tx_flit,
  output logic [AW-1:0]        tx_seq,
  input  logic                 ack_valid,
  input  logic [AW-1:0]        ack_seq,
  input  logic                 nak_valid,
  input  logic [AW-1:0]        nak_seq,
  input  logic                 credit_ret
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // window pointers carry one wrap bit
  logic [AW:0] base_q, base_d, wr_q, wr_d, rd_q, rd_d;
  logic        replay_q, replay_d;
  logic [AW:0] held;
  logic        full, accept, rep_go, has_credit;
  logic [AW-1:0] ack_off, nak_off;
  logic [15:0]   crc_new;
  logic [FLIT_W-1:0] new_flit, rd_flit;
  logic [CW-1:0] credit_cnt;
  logic              txv_d;
  logic [FLIT_W-1:0] txf_d;
  logic [AW-1:0]     txs_d;

  flit_crc16 #(.DATA_W(PAYLOAD_W)) u_crc (.data(in_data), .crc(crc_new));
  assign new_flit = {in_data, crc_new};

  flit_replay_buf #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .wr_en(accept), .wr_idx(wr_q[AW-1:0]), .wr_data(new_flit),
    .rd_idx(rd_q[AW-1:0]), .rd_data(rd_flit));

  flit_credit_ctr #(.RX_BUF(RX_BUF)) u_cred (
    .clk(clk), .rst_n(rst_n_s), .inc(credit_ret), .dec(accept),
    .count(credit_cnt), .has_credit(has_credit));

  assign held     = wr_q - base_q;
  assign full     = (held == (AW+1)'(DEPTH));
  assign in_ready = rst_n_s && !replay_q && !nak_valid && has_credit && !full;
  assign accept   = in_valid && in_ready;
  assign rep_go   = replay_q && (rd_q != wr_q);
  assign ack_off  = ack_seq - base_q[AW-1:0];
  assign nak_off  = nak_seq - base_q[AW-1:0];

  // next-state
  always_comb begin
    wr_d     = wr_q + (AW+1)'(accept);
    base_d   = base_q;
    rd_d     = rd_q;
    replay_d = replay_q;
    if (ack_valid) base_d = base_q + (AW+1)'(ack_off) + (AW+1)'(1);
    if (nak_valid) begin
      rd_d     = base_q + (AW+1)'(nak_off);
      replay_d = 1'b1;
    end else if (rep_go) begin
      rd_d     = rd_q + (AW+1)'(1);
      replay_d = ((rd_q + (AW+1)'(1)) != wr_q);
    end else if (replay_q) begin
      replay_d = 1'b0;
    end else begin
      rd_d = wr_d;
    end
    txv_d = accept || rep_go;
    txf_d = accept ? new_flit : rd_flit;
    txs_d = accept ? wr_q[AW-1:0] : rd_q[AW-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      base_q   <= '0;
      wr_q     <= '0;
      rd_q     <= '0;
      replay_q <= 1'b0;
      tx_valid <= 1'b0;
    end else begin
      base_q   <= base_d;
      wr_q     <= wr_d;
      rd_q     <= rd_d;
      replay_q <= replay_d;
      tx_valid <= txv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      tx_flit <= '0;
      tx_seq  <= '0;
    end else if (txv_d) begin
      tx_flit <= txf_d;
      tx_seq  <= txs_d;
    end
  end

  AST_HELD_BOUND: assert property (@(posedge clk) disable iff (!rst_n_s)
    held <= (AW+1)'(DEPTH)); // R9
  AST_NAK_REPLAY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (nak_valid && (held != '0)) ##1 !nak_valid |=> (tx_valid && tx_seq == $past(nak_seq, 2))); // R7
  AST_REPLAY_HOLDS_WR: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(replay_q) && !$past(nak_valid)) |-> (wr_q == $past(wr_q))); // R7
  AST_REPLAY_NO_CREDIT: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(rep_go) && !$past(credit_ret)) |-> (credit_cnt == $past(credit_cnt))); // R8
endmodule

// File: tb/flit_tx_link_test.sv
module flit_tx_link_test;
  localparam int PW = 16;
  localparam int DP = 4;
  localparam int RB = 6;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, tx_valid;
  logic [PW-1:0] in_data;
  logic [PW+15:0] tx_flit;
  logic [AW-1:0] tx_seq, ack_seq, nak_seq;
  logic ack_valid, nak_valid, credit_ret;

  always #4 clk = ~clk; // 125 MHz

  flit_tx_link #(.PAYLOAD_W(PW), .DEPTH(DP), .RX_BUF(RB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tx_valid(tx_valid), .tx_flit(tx_flit), .tx_seq(tx_seq),
    .ack_valid(ack_valid), .ack_seq(ack_seq), .nak_valid(nak_valid),
    .nak_seq(nak_seq), .credit_ret(credit_ret));

  int total = 0;
  int fails = 0;
  logic [PW-1:0] sent [DP];
  int nseq = 0;

  // reference CRC with explicit taps of x^16 + x^12 + x^5 + 1
  function automatic logic [15:0] ref_crc(input logic [PW-1:0] d);
    logic [15:0] r;
    logic f;
    r = 16'hFFFF;
    for (int i = PW - 1; i >= 0; i--) begin
      f = r[15] ^ d[i];
      r = {r[14:12], r[11] ^ f, r[10:5], r[4] ^ f, r[3:0], f};
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1 R2: push one payload and check the flit right after the edge
  task automatic send(input logic [PW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    chk("R2 ready before send", 64'(in_ready), 64'(1));
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 tx_valid", 64'(tx_valid), 64'(1));
    chk("R2 seq", 64'(tx_seq), 64'(nseq % DP));
    chk("R1 flit", 64'(tx_flit), 64'({d, ref_crc(d)}));
    sent[nseq % DP] = d;
    nseq++;
  endtask

  task automatic ack(input int s);
    @(negedge clk);
    ack_valid = 1'b1;
    ack_seq   = AW'(s);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic cred(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      credit_ret = 1'b1;
    end
    @(negedge clk);
    credit_ret = 1'b0;
  endtask

  // R7: rewind to s, expect cnt resent flits
  task automatic nak(input int s, input int cnt);
    @(negedge clk);
    nak_valid = 1'b1;
    nak_seq   = AW'(s);
    @(negedge clk);
    nak_valid = 1'b0;
    chk("R7 gap cycle", 64'(tx_valid), 64'(0));
    chk("R7 ready low", 64'(in_ready), 64'(0));
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk);
      chk("R7 replay valid", 64'(tx_valid), 64'(1));
      chk("R7 replay seq", 64'(tx_seq), 64'((s + k) % DP));
      chk("R7 replay flit", 64'(tx_flit),
          64'({sent[(s + k) % DP], ref_crc(sent[(s + k) % DP])}));
      if (k < cnt - 1) chk("R7 ready low during", 64'(in_ready), 64'(0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    ack_valid = 1'b0; ack_seq = '0; nak_valid = 1'b0; nak_seq = '0; credit_ret = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 tx_valid", 64'(tx_valid), 64'(0));
    chk("R3 in_ready", 64'(in_ready), 64'(1));

    // fill the store: 4 held, 2 credits left
    send(16'h0000); send(16'hFFFF); send(16'hA5C3); send(16'h1234);
    @(negedge clk);
    chk("R9 full blocks", 64'(in_ready), 64'(0));

    nak(1, 3);
    @(negedge clk);
    chk("R9 still full", 64'(in_ready), 64'(0));
    ack(1);
    chk("R6 ack frees 0..1", 64'(in_ready), 64'(1));
    nak(2, 2);
    ack(3);
    chk("R6 empty after ack", 64'(in_ready), 64'(1));

    // two credits remain only if replays cost none
    send(16'h8001); send(16'h7FFE);
    @(negedge clk);
    chk("R5 no credit", 64'(in_ready), 64'(0));
    chk("R8 replay cost none", 64'(nseq), 64'(6));
    cred(1);
    chk("R4 one credit back", 64'(in_ready), 64'(1));
    send(16'h5555);
    @(negedge clk);
    chk("R5 spent again", 64'(in_ready), 64'(0));
    ack(2);
    cred(3);
    chk("R4 credits back", 64'(in_ready), 64'(1));

    // sweep of payloads; keep credits topped up
    for (int i = 0; i < 48; i++) begin
      logic [PW-1:0] p;
      p = PW'((i * 16'h1357) ^ (16'h0001 << (i % PW)));
      send(p);
      ack((nseq - 1) % DP);
      cred(1);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule